// File: doc/BRIEF.md
# Tagged Receive Byte Queue

This block sits between a serial receiver and a host. Each character the receiver assembles arrives as a byte plus three error tags: a parity mismatch, a missing stop bit, and a break. The byte and its three tags go into a 16-entry first-in first-out queue. The tags stay attached to their own byte, so the host always sees the error state of the character it is about to take. The host takes the head entry with a one-cycle pop strobe. The head byte and its tags are visible combinationally at all times. They read as zero when the queue is empty.

The host picks one of four fill thresholds with a 2-bit select. A data request output is high while the fill level is at or above the chosen threshold. An active-low ready output falls when the threshold is reached and stays low until the queue is completely drained.

A character that arrives while the queue is full is dropped and sets a sticky overrun flag, which the host clears explicitly. A flush strobe empties the queue and wipes every stored tag in a single clock.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: After reset the queue is empty: fill level 0, `empty` high, `full` low, `data_req` low, `rx_ready_n` high, `overrun` low, and all head outputs zero.
- R2: Entries leave in arrival order, and the head outputs carry the byte together with the parity, framing and break tags that were written with that same byte.
- R3: On each clock edge an accepted write raises the fill level by one and an accepted pop lowers it by one (both together leave it unchanged). `full` is high exactly at level 16 and `empty` exactly at level 0.
- R4: A pop while the queue is empty is ignored. The level stays 0 and the head outputs stay zero.
- R5: A write while the queue is full is discarded, even if a pop occurs on the same edge. The stored entries and level stay unchanged, and `overrun` goes high on that edge.
- R6: `overrun` stays high until a cycle with `ovr_clr` high. If an overflowing write coincides with `ovr_clr`, the flag is set.
- R7: `data_req` is high exactly while the fill level is at or above the threshold selected by `trig_sel`: 0 selects 1 entry, 1 selects 4, 2 selects 8, 3 selects 14.
- R8: `rx_ready_n` goes low on the edge where the fill level reaches the selected threshold. It returns high only on the edge where the level becomes 0.
- R9: `flush` empties the queue in one clock and clears all stored tags. It takes priority over a write or pop on the same edge, and it leaves `overrun` unchanged.
- R10: While the queue is empty, `head_data`, `head_perr`, `head_ferr` and `head_brk` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Receiver presents a character this cycle |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error tag of the byte |
| wr_ferr | input | 1 | Framing error tag of the byte |
| wr_brk | input | 1 | Break tag of the byte |
| rd_pop | input | 1 | Host removes the head entry |
| flush | input | 1 | Empty the queue and clear tags |
| ovr_clr | input | 1 | Clear the overrun flag |
| trig_sel | input | 2 | Threshold select (1, 4, 8, 14 entries) |
| head_data | output | 8 | Byte at the head, zero when empty |
| head_perr | output | 1 | Parity tag of the head entry |
| head_ferr | output | 1 | Framing tag of the head entry |
| head_brk | output | 1 | Break tag of the head entry |
| fill_level | output | 5 | Number of stored entries |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds 16 entries |
| data_req | output | 1 | Fill level at or above threshold |
| rx_ready_n | output | 1 | Active-low ready with drain hysteresis |
| overrun | output | 1 | Sticky overflow flag |

## Verification
On every cycle the assertions check the following. The level never exceeds the depth and moves by at most one step between flushes. An overflowing write sets the flag and leaves the queue full. A flush empties the queue. The overrun flag holds until it is cleared. Ready and request are never active while the queue is empty. The head outputs are zero whenever the queue is empty.

Only the bench's scenarios can show two properties. The first is that the bytes and their tags come out in order and still paired. The second is that the ready output's hysteresis follows the selected threshold as the select changes. The bench compares each step against a reference queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // Per-character error tags kept alongside each stored byte
   typedef struct packed {
      logic brk;
      logic ferr;
      logic perr;
   } rxq_tag_t;

   localparam int TAG_W = $bits(rxq_tag_t);

endpackage

// File: rtl/rxq_ctrl.sv
// Pointer, level and overrun bookkeeping of the tagged queue
module rxq_ctrl #(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   input  logic             rd_pop,
   input  logic             flush,
   input  logic             ovr_clr,
   output logic             push_ok,
   output logic [AW-1:0]    wr_ptr,
   output logic [AW-1:0]    rd_ptr,
   output logic [LVL_W-1:0] level,
   output logic [LVL_W-1:0] level_nxt,
   output logic             is_empty,
   output logic             is_full,
   output logic             ovr_flag
);

   localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

   logic pop_ok;
   logic ovr_set;

   assign is_full  = (level == LVL_FULL);
   assign is_empty = (level == '0);

   // Acceptance is decided from the state before the edge
   assign push_ok = wr_valid & ~is_full  & ~flush;
   assign pop_ok  = rd_pop   & ~is_empty & ~flush;
   assign ovr_set = wr_valid &  is_full  & ~flush;

   always_comb begin
      if (flush) begin
         level_nxt = '0;
      end else begin
         level_nxt = level + LVL_W'(push_ok) - LVL_W'(pop_ok);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
         level <= level_nxt;
      end
   end

   // Sticky overflow flag; a new overflow wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_flag <= 1'b0;
      end else if (ovr_set) begin
         ovr_flag <= 1'b1;
      end else if (ovr_clr) begin
         ovr_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/rxq_store.sv
// Entry storage: byte plus tag per slot, cleared by reset or flush
module rxq_store #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter int AW     = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  wr_en,
   input  logic [AW-1:0]         wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  rxq_pkg::rxq_tag_t     wr_tag,
   input  logic [AW-1:0]         rd_addr,
   input  logic                  is_empty,
   output logic [DATA_W-1:0]     rd_data,
   output rxq_pkg::rxq_tag_t     rd_tag
);

   logic [DATA_W-1:0]  data_q [DEPTH];
   rxq_pkg::rxq_tag_t  tag_q  [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            data_q[i] <= '0;
            tag_q[i]  <= '0;
         end
      end else if (flush) begin
         for (int i = 0; i < DEPTH; i++) begin
            data_q[i] <= '0;
            tag_q[i]  <= '0;
         end
      end else if (wr_en) begin
         data_q[wr_addr] <= wr_data;
         tag_q[wr_addr]  <= wr_tag;
      end
   end

   // Head view, forced to zero when nothing is stored
   always_comb begin
      if (is_empty) begin
         rd_data = '0;
         rd_tag  = '0;
      end else begin
         rd_data = data_q[rd_addr];
         rd_tag  = tag_q[rd_addr];
      end
   end

endmodule

// File: rtl/rxq_thresh.sv
// Threshold select, data request and active-low ready output
module rxq_thresh #(
   parameter int LVL_W      = 5,
   parameter int TRIG_L0    = 1,
   parameter int TRIG_L1    = 4,
   parameter int TRIG_L2    = 8,
   parameter int TRIG_L3    = 14,
   parameter bit READY_HYST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       trig_sel,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] level_nxt,
   output logic             data_req,
   output logic             rx_ready_n
);

   logic [LVL_W-1:0] thr;
   logic             rdy_q;

   always_comb begin
      unique case (trig_sel)
         2'd0:    thr = LVL_W'(TRIG_L0);
         2'd1:    thr = LVL_W'(TRIG_L1);
         2'd2:    thr = LVL_W'(TRIG_L2);
         default: thr = LVL_W'(TRIG_L3);
      endcase
   end

   assign data_req = (level >= thr);

   generate
      if (READY_HYST) begin : g_hyst
         // Assert at threshold, release only once drained
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdy_q <= 1'b0;
            end else if (level_nxt >= thr) begin
               rdy_q <= 1'b1;
            end else if (level_nxt == '0) begin
               rdy_q <= 1'b0;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdy_q <= 1'b0;
            end else begin
               rdy_q <= (level_nxt >= thr);
            end
         end
      end
   endgenerate

   assign rx_ready_n = ~rdy_q;

endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo #(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 16,
   parameter int TRIG_L0    = 1,
   parameter int TRIG_L1    = 4,
   parameter int TRIG_L2    = 8,
   parameter int TRIG_L3    = 14,
   parameter bit READY_HYST = 1'b1,
   localparam int AW        = $clog2(DEPTH),
   localparam int LVL_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_perr,
   input  logic              wr_ferr,
   input  logic              wr_brk,
   input  logic              rd_pop,
   input  logic              flush,
   input  logic              ovr_clr,
   input  logic [1:0]        trig_sel,
   output logic [DATA_W-1:0] head_data,
   output logic              head_perr,
   output logic              head_ferr,
   output logic              head_brk,
   output logic [LVL_W-1:0]  fill_level,
   output logic              empty,
   output logic              full,
   output logic              data_req,
   output logic              rx_ready_n,
   output logic              overrun
);

   // Elaboration-time parameter checks
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxq_tagged_fifo: DEPTH must be a power of two, at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rxq_tagged_fifo: DATA_W must be positive");
      end
      if (TRIG_L0 < 1 || TRIG_L0 >= TRIG_L1 || TRIG_L1 >= TRIG_L2 ||
          TRIG_L2 >= TRIG_L3 || TRIG_L3 > DEPTH) begin : g_bad_trig
         $error("rxq_tagged_fifo: thresholds must rise strictly within 1..DEPTH");
      end
   endgenerate

   logic              push_ok;
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   logic [LVL_W-1:0]  level_nxt;
   rxq_pkg::rxq_tag_t in_tag;
   rxq_pkg::rxq_tag_t out_tag;

   assign in_tag = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr};

   rxq_ctrl #(.DEPTH(DEPTH), .AW(AW), .LVL_W(LVL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_valid  (wr_valid),
      .rd_pop    (rd_pop),
      .flush     (flush),
      .ovr_clr   (ovr_clr),
      .push_ok   (push_ok),
      .wr_ptr    (wr_ptr),
      .rd_ptr    (rd_ptr),
      .level     (fill_level),
      .level_nxt (level_nxt),
      .is_empty  (empty),
      .is_full   (full),
      .ovr_flag  (overrun)
   );

   rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (push_ok),
      .wr_addr  (wr_ptr),
      .wr_data  (wr_data),
      .wr_tag   (in_tag),
      .rd_addr  (rd_ptr),
      .is_empty (empty),
      .rd_data  (head_data),
      .rd_tag   (out_tag)
   );

   rxq_thresh #(
      .LVL_W(LVL_W), .TRIG_L0(TRIG_L0), .TRIG_L1(TRIG_L1),
      .TRIG_L2(TRIG_L2), .TRIG_L3(TRIG_L3), .READY_HYST(READY_HYST)
   ) u_thresh (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_sel   (trig_sel),
      .level      (fill_level),
      .level_nxt  (level_nxt),
      .data_req   (data_req),
      .rx_ready_n (rx_ready_n)
   );

   assign head_perr = out_tag.perr;
   assign head_ferr = out_tag.ferr;
   assign head_brk  = out_tag.brk;

endmodule

// File: rtl/rxq_tagged_fifo_chk.sv
module rxq_tagged_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int LVL_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              rd_pop,
   input logic              flush,
   input logic              ovr_clr,
   input logic [DATA_W-1:0] head_data,
   input logic              head_perr,
   input logic              head_ferr,
   input logic              head_brk,
   input logic [LVL_W-1:0]  fill_level,
   input logic              empty,
   input logic              full,
   input logic              data_req,
   input logic              rx_ready_n,
   input logic              overrun
);

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fill_level <= LVL_W'(DEPTH));

   a_r3_level_step: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> ({1'b0, fill_level} <= {1'b0, $past(fill_level)} + 1'b1) &&
                 ({1'b0, fill_level} + 1'b1 >= {1'b0, $past(fill_level)}));

   a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_pop && !wr_valid) |=> empty);

   a_r5_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_valid && !flush) |=> overrun);

   a_r5_full_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_valid && !rd_pop && !flush) |=> full);

   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !ovr_clr) |=> overrun);

   a_r7_req_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      data_req |-> !empty);

   a_r8_ready_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready_n |-> !empty);

   a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_ready_n && !flush && fill_level > 1) |=> !rx_ready_n);

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && fill_level == '0));

   a_r10_empty_head_zero: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (head_data == '0 && !head_perr && !head_ferr && !head_brk));

endmodule

bind rxq_tagged_fifo rxq_tagged_fifo_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid   (wr_valid),
   .rd_pop     (rd_pop),
   .flush      (flush),
   .ovr_clr    (ovr_clr),
   .head_data  (head_data),
   .head_perr  (head_perr),
   .head_ferr  (head_ferr),
   .head_brk   (head_brk),
   .fill_level (fill_level),
   .empty      (empty),
   .full       (full),
   .data_req   (data_req),
   .rx_ready_n (rx_ready_n),
   .overrun    (overrun)
);

// File: tb/rxq_tagged_fifo_tb.sv
`timescale 1ns/1ps
module rxq_tagged_fifo_tb_top;

   localparam int DW    = 8;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_valid, wr_perr, wr_ferr, wr_brk;
   logic [DW-1:0] wr_data;
   logic          rd_pop, flush, ovr_clr;
   logic [1:0]    trig_sel;
   logic [DW-1:0] head_data;
   logic          head_perr, head_ferr, head_brk;
   logic [4:0]    fill_level;
   logic          empty, full, data_req, rx_ready_n, overrun;

   always #5 clk = ~clk;

   rxq_tagged_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
      .rd_pop(rd_pop), .flush(flush), .ovr_clr(ovr_clr), .trig_sel(trig_sel),
      .head_data(head_data), .head_perr(head_perr), .head_ferr(head_ferr),
      .head_brk(head_brk), .fill_level(fill_level), .empty(empty), .full(full),
      .data_req(data_req), .rx_ready_n(rx_ready_n), .overrun(overrun)
   );

   int n_chk  = 0;
   int n_fail = 0;

   // Reference model: {brk, ferr, perr, data} per entry
   logic [DW+2:0] mq[$];
   bit            m_ovr = 1'b0;
   bit            m_rdy = 1'b0;

   function automatic int trig_of(logic [1:0] s);
      case (s)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_edge();
      int sz = mq.size();
      if (flush) begin
         mq.delete();
      end else begin
         if (rd_pop && sz > 0) void'(mq.pop_front());
         if (wr_valid && sz < DEPTH) mq.push_back({wr_brk, wr_ferr, wr_perr, wr_data});
      end
      if (ovr_clr) m_ovr = 1'b0;
      if (!flush && wr_valid && sz == DEPTH) m_ovr = 1'b1;
      if (mq.size() >= trig_of(trig_sel)) m_rdy = 1'b1;
      else if (mq.size() == 0) m_rdy = 1'b0;
   endtask

   task automatic check_all();
      logic [DW+2:0] hd;
      int lvl = mq.size();
      hd = (lvl > 0) ? mq[0] : '0;
      chk("R3 level", int'(fill_level), lvl);
      chk("R3 empty", int'(empty), int'(lvl == 0));
      chk("R3 full", int'(full), int'(lvl == DEPTH));
      chk("R2 head byte", int'(head_data), int'(hd[DW-1:0]));
      chk("R2 head tags", int'({head_brk, head_ferr, head_perr}), int'(hd[DW+2:DW]));
      chk("R7 data_req", int'(data_req), int'(lvl >= trig_of(trig_sel)));
      chk("R8 rx_ready_n", int'(rx_ready_n), int'(!m_rdy));
      chk("R6 overrun", int'(overrun), int'(m_ovr));
   endtask

   task automatic idle_inputs();
      wr_valid = 0; wr_data = '0; wr_perr = 0; wr_ferr = 0; wr_brk = 0;
      rd_pop = 0; flush = 0; ovr_clr = 0;
   endtask

   task automatic cyc();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all();
   endtask

   task automatic put(logic [DW-1:0] d, logic [2:0] t);
      wr_valid = 1; wr_data = d; {wr_brk, wr_ferr, wr_perr} = t;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      idle_inputs();
      trig_sel = 2'd0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 level", int'(fill_level), 0);
      chk("R1 empty", int'(empty), 1);
      chk("R1 ready", int'(rx_ready_n), 1);
      chk("R1 req/ovr/full", int'({data_req, overrun, full}), 0);
      chk("R1 head", int'({head_brk, head_ferr, head_perr, head_data}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: pop on empty ignored
      rd_pop = 1; cyc(); rd_pop = 0;
      chk("R4 still empty", int'(empty), 1);
      chk("R10 head zero", int'({head_brk, head_ferr, head_perr, head_data}), 0);

      // Fill to full with distinct bytes and tags, top threshold
      trig_sel = 2'd3;
      for (int i = 0; i < DEPTH; i++) begin
         put(8'hA0 + 8'(i), 3'(i)); cyc();
         if (i == 12) chk("R8 not ready below 14", int'(rx_ready_n), 1);
      end
      chk("R8 ready at 14+", int'(rx_ready_n), 0);
      // R5: write while full, with a simultaneous pop
      put(8'h55, 3'b111); rd_pop = 1; cyc(); rd_pop = 0;
      chk("R5 overrun set", int'(overrun), 1);
      chk("R5 level after pop", int'(fill_level), DEPTH - 1);
      put(8'h5A, 3'b101); cyc();
      // R5: full write alone keeps contents
      put(8'h66, 3'b111); cyc();
      chk("R5 head kept", int'(head_data), 8'hA1);
      // R6: set wins over clear
      put(8'h67, 3'b000); ovr_clr = 1; cyc();
      chk("R6 set beats clear", int'(overrun), 1);
      wr_valid = 0; cyc(); ovr_clr = 0;
      chk("R6 cleared", int'(overrun), 0);
      // Drain completely; R8 hysteresis stays low until empty
      for (int i = 0; i < DEPTH; i++) begin
         rd_pop = 1; cyc();
         if (i == 10) chk("R8 held while draining", int'(rx_ready_n), 0);
      end
      rd_pop = 0;
      chk("R8 released at empty", int'(rx_ready_n), 1);

      // R9: flush with coincident write, overrun untouched
      trig_sel = 2'd1;
      for (int i = 0; i < DEPTH + 1; i++) begin put(8'(i), 3'b010); cyc(); end
      wr_valid = 0;
      put(8'hEE, 3'b111); flush = 1; cyc(); flush = 0; wr_valid = 0;
      chk("R9 empty after flush", int'(empty), 1);
      chk("R9 overrun kept", int'(overrun), 1);
      chk("R9 tags cleared", int'({head_brk, head_ferr, head_perr}), 0);
      ovr_clr = 1; cyc(); ovr_clr = 0;

      // Random phases biased toward fill and drain
      for (int ph = 0; ph < 40; ph++) begin
         int wp = (ph % 2 == 0) ? 80 : 25;
         int rp = (ph % 2 == 0) ? 25 : 80;
         for (int c = 0; c < 100; c++) begin
            wr_valid = ($urandom % 100) < wp;
            wr_data  = DW'($urandom);
            {wr_brk, wr_ferr, wr_perr} = 3'($urandom);
            rd_pop   = ($urandom % 100) < rp;
            flush    = ($urandom % 200) == 0;
            ovr_clr  = ($urandom % 30) == 0;
            if (($urandom % 40) == 0) trig_sel = 2'($urandom);
            cyc();
         end
      end
      idle_inputs();
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule